// File: doc/BRIEF.md
# Granted-Master Stall Guard

This block sits next to a bus arbiter that serves five request/grant pairs, one for an on-chip master and four for masters off the chip. It watches which master currently holds the grant and whether that master actually opens a transaction once the bus is free. A master that keeps requesting and keeps its grant, but starts no address phase within a fixed number of idle-bus clocks, is declared stalled. From then on its request line toward the arbiter is forced low, so the arbiter can serve the remaining requesters.

Each master has a sticky stall flag, and a one-clock report pulse tells the host when a new flag has been raised. The host releases a master by pulsing that master's bit on the clear input. All requests and grants are active-high here. Bus polarity is converted outside the block. The frame and initiator-ready inputs are registered copies of the bus signals and are never taken straight from the pins.

Top module: `bus_stall_guard`

## Requirements
- R1: `req_out` equals `req_in` with every bit whose stall flag is set forced to 0. Bit i belongs to master i, with bit 0 the on-chip master.
- R2: A clock counts as bus-idle only when `frame_q` and `irdy_q` are both 0. While either one is 1, no stall is detected, however long the grant is held.
- R3: When the granted master (the single 1 in `gnt_in`) keeps its request and grant through IDLE_LIMIT (default 16) clocks, counted from the first idle clock, with no address phase, its stall flag is 1 after the clock edge that ends the IDLE_LIMIT-th clock.
- R4: An address phase is a clock in which `frame_q` is 1 and was 0 in the previous clock. It restarts the window, so a master that opens a transaction at least once every IDLE_LIMIT-1 clocks is never flagged.
- R5: A change of `gnt_in`, or the granted master dropping its request, restarts the window.
- R6: A stall flag stays set until the host clears it, whatever the later activity on the bus.
- R7: `report_o` is 1 for exactly the one clock that follows the edge at which a flag goes from 0 to 1. At all other times it is 0.
- R8: A 1 on `clr_in[i]` clears flag i at the next edge and unmasks that request. When a clear and a detection fall in the same clock, the clear wins: no flag is set and no report is made.
- R9: While `rst` is 1 (synchronous, active-high), `req_out` is 0, the flags and `report_o` are cleared at each edge, and no flag is raised however long the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | NUM_MASTERS | Raw requests, bit 0 is the on-chip master |
| gnt_in | input | NUM_MASTERS | One-hot grants from the arbiter |
| frame_q | input | 1 | Registered frame, 1 = asserted |
| irdy_q | input | 1 | Registered initiator ready, 1 = asserted |
| clr_in | input | NUM_MASTERS | Host clear, one bit per master |
| req_out | output | NUM_MASTERS | Masked requests toward the arbiter |
| broken_o | output | NUM_MASTERS | Sticky stall flags |
| report_o | output | 1 | One-clock pulse on a newly set flag |

## Verification
The bench runs a granted master through a plain idle stretch and samples one clock before and one clock after the expected detection edge, which pins the window length to exactly IDLE_LIMIT. Other runs hold the grant with `irdy_q` high or with `frame_q` high and steady, which tells the two-signal idle test apart from a frame-only one and a rising-edge address detector apart from a level detector. Periodic frame pulses, brief grant moves and request drops each restart the window. A clear placed on the very clock of detection shows the precedence rule, and a long idle stretch held in reset shows that nothing is flagged during reset.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  localparam int DEF_MASTERS    = 5;
  localparam int DEF_IDLE_LIMIT = 16;
endpackage

// File: rtl/bsg_bus_watch.sv
module bsg_bus_watch (
  input  logic clk,
  input  logic rst,
  input  logic frame_q,
  input  logic irdy_q,
  output logic bus_idle,
  output logic addr_seen
);
  logic frame_prev;

  always_ff @(posedge clk) begin
    if (rst) frame_prev <= 1'b0;
    else     frame_prev <= frame_q;
  end

  assign bus_idle  = ~frame_q & ~irdy_q;
  assign addr_seen = frame_q & ~frame_prev;
endmodule

// File: rtl/bsg_idle_timer.sv
module bsg_idle_timer #(
  parameter int IDLE_LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic bus_idle,
  output logic expire
);
  localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  // A nonzero count means the window is open; the first idle clock opens it.
  assign expire = ~restart & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || expire)        cnt <= '0;
    else if ((cnt != '0) || bus_idle)    cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/bsg_fault_flags.sv
module bsg_fault_flags #(
  parameter int NUM_MASTERS = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   expire,
  input  logic [NUM_MASTERS-1:0] gnt_in,
  input  logic [NUM_MASTERS-1:0] clr_in,
  output logic [NUM_MASTERS-1:0] flags,
  output logic                   report
);
  logic [NUM_MASTERS-1:0] hit;
  logic [NUM_MASTERS-1:0] fresh;

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_flag
    assign hit[i]   = expire & gnt_in[i];
    assign fresh[i] = hit[i] & ~clr_in[i] & ~flags[i];

    always_ff @(posedge clk) begin
      if (rst || clr_in[i]) flags[i] <= 1'b0;
      else if (hit[i])      flags[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) report <= 1'b0;
    else     report <= |fresh;
  end
endmodule

// File: rtl/bus_stall_guard.sv
module bus_stall_guard
  import bsg_pkg::*;
#(
  parameter int NUM_MASTERS = DEF_MASTERS,
  parameter int IDLE_LIMIT  = DEF_IDLE_LIMIT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] req_in,
  input  logic [NUM_MASTERS-1:0] gnt_in,
  input  logic                   frame_q,
  input  logic                   irdy_q,
  input  logic [NUM_MASTERS-1:0] clr_in,
  output logic [NUM_MASTERS-1:0] req_out,
  output logic [NUM_MASTERS-1:0] broken_o,
  output logic                   report_o
);
  logic [NUM_MASTERS-1:0] owner_q;
  logic bus_idle, addr_seen, watching, restart, expire;

  always_ff @(posedge clk) begin
    if (rst) owner_q <= '0;
    else     owner_q <= gnt_in;
  end

  bsg_bus_watch u_watch (
    .clk(clk), .rst(rst), .frame_q(frame_q), .irdy_q(irdy_q),
    .bus_idle(bus_idle), .addr_seen(addr_seen)
  );

  assign watching = |(gnt_in & req_in & ~broken_o);
  assign restart  = (gnt_in != owner_q) | ~watching | addr_seen;

  bsg_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .bus_idle(bus_idle),
    .expire(expire)
  );

  bsg_fault_flags #(.NUM_MASTERS(NUM_MASTERS)) u_flags (
    .clk(clk), .rst(rst), .expire(expire), .gnt_in(gnt_in),
    .clr_in(clr_in), .flags(broken_o), .report(report_o)
  );

  assign req_out = rst ? '0 : (req_in & ~broken_o);
endmodule

// File: rtl/bus_stall_guard_chk.sv
module bus_stall_guard_chk #(
  parameter int NUM_MASTERS = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_MASTERS-1:0] clr_in,
  input logic [NUM_MASTERS-1:0] req_out,
  input logic [NUM_MASTERS-1:0] broken_o,
  input logic                   report_o
);
  p_mask_r1: assert property (@(posedge clk) disable iff (rst)
    (req_out & broken_o) == '0);

  p_single_new_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(broken_o & ~$past(broken_o)));

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((broken_o & $past(broken_o & ~clr_in)) == $past(broken_o & ~clr_in)));

  p_report_r7: assert property (@(posedge clk) disable iff (rst)
    report_o == (|(broken_o & ~$past(broken_o))));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (|clr_in) |=> ((broken_o & $past(clr_in)) == '0));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (broken_o == '0 && !report_o));
endmodule

bind bus_stall_guard bus_stall_guard_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk(clk), .rst(rst), .clr_in(clr_in), .req_out(req_out),
  .broken_o(broken_o), .report_o(report_o)
);

// File: tb/sim_bus_stall_guard.sv
module sim_bus_stall_guard;
  localparam int N = 5;
  localparam int LIM = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0, gnt = '0, clr = '0;
  logic frm = 1'b0, ird = 1'b0;
  logic [N-1:0] req_out, broken_o;
  logic report_o;

  int checks = 0, fails = 0;

  // reference state: values after the last clock edge
  logic [N-1:0] m_flags = '0, m_owner = '0;
  logic m_rep = 1'b0, m_prevf = 1'b0;
  int m_run = 0;

  bus_stall_guard #(.NUM_MASTERS(N), .IDLE_LIMIT(LIM)) u0 (
    .clk(clk), .rst(rst), .req_in(req), .gnt_in(gnt), .frame_q(frm),
    .irdy_q(ird), .clr_in(clr), .req_out(req_out), .broken_o(broken_o),
    .report_o(report_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic fire;
    logic [N-1:0] nf;
    fire = 1'b0;
    if (rst) begin
      m_flags = '0; m_rep = 1'b0; m_run = 0; m_prevf = 1'b0; m_owner = '0;
    end else begin
      if (gnt != m_owner || (gnt & req & ~m_flags) == '0 || (frm && !m_prevf))
        m_run = 0;
      else if (m_run > 0 || (!frm && !ird)) begin
        m_run = m_run + 1;
        if (m_run == LIM) begin fire = 1'b1; m_run = 0; end
      end
      nf = (m_flags | (fire ? gnt : '0)) & ~clr;
      m_rep = |(nf & ~m_flags);
      m_flags = nf;
      m_owner = gnt;
      m_prevf = frm;
    end
  endtask

  task automatic cyc(input logic r, input logic [N-1:0] q, input logic [N-1:0] g,
                     input logic f, input logic i, input logic [N-1:0] c);
    @(negedge clk);
    rst = r; req = q; gnt = g; frm = f; ird = i; clr = c;
    #1;
    chk(req_out, r ? '0 : (q & ~m_flags), "R1 masked requests");
    chk(broken_o, m_flags, "R3 flags vs model");
    chk({4'b0, report_o}, {4'b0, m_rep}, "R7 report vs model");
    model_step();
  endtask

  task automatic idle(input int n, input logic [N-1:0] q, input logic [N-1:0] g);
    for (int k = 0; k < n; k++) cyc(1'b0, q, g, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R9: reset with requests and a long idle grant
    for (int k = 0; k < 20; k++) cyc(1'b1, 5'h1F, 5'h04, 1'b0, 1'b0, '0);
    chk(req_out, '0, "R9 req_out in reset");
    cyc(1'b0, 5'h04, 5'h04, 1'b1, 1'b0, '0);
    chk(broken_o, '0, "R9 no flag from reset idle");
    chk({4'b0, report_o}, '0, "R9 report after reset");

    // R3: master 2 stalls
    cyc(1'b0, 5'h04, 5'h04, 1'b1, 1'b0, '0);
    idle(16, 5'h04, 5'h04);
    chk(broken_o, '0, "R3 not yet after 15 idle");
    cyc(1'b0, 5'h04, 5'h04, 1'b0, 1'b0, '0);
    chk(broken_o, 5'h04, "R3 flag after 16 idle");
    chk({4'b0, report_o}, 5'h01, "R7 report pulse");
    cyc(1'b0, 5'h04, 5'h04, 1'b0, 1'b0, '0);
    chk({4'b0, report_o}, '0, "R7 pulse one clock");

    // R6/R1: sticky, masked
    for (int k = 0; k < 10; k++) cyc(1'b0, 5'h06, (k % 2) ? 5'h02 : 5'h04, k[0], 1'b0, '0);
    chk(broken_o, 5'h04, "R6 flag sticky");
    chk(req_out, 5'h02, "R1 request 2 masked");

    // R2: irdy high, then frame high and steady
    cyc(1'b0, 5'h02, 5'h02, 1'b1, 1'b0, '0);
    for (int k = 0; k < 30; k++) cyc(1'b0, 5'h02, 5'h02, 1'b0, 1'b1, '0);
    for (int k = 0; k < 30; k++) cyc(1'b0, 5'h02, 5'h02, 1'b1, 1'b0, '0);
    cyc(1'b0, 5'h02, 5'h02, 1'b1, 1'b1, '0);
    chk(broken_o, 5'h04, "R2 no stall while bus busy");

    // R4: address phases every 11 clocks
    for (int p = 0; p < 4; p++) begin
      idle(10, 5'h02, 5'h02);
      cyc(1'b0, 5'h02, 5'h02, 1'b1, 1'b0, '0);
    end
    cyc(1'b0, 5'h02, 5'h02, 1'b1, 1'b0, '0);
    chk(broken_o, 5'h04, "R4 address phases restart window");

    // R5: grant move and request drop
    idle(12, 5'h0A, 5'h08);
    cyc(1'b0, 5'h1A, 5'h10, 1'b0, 1'b0, '0);
    idle(12, 5'h0A, 5'h08);
    cyc(1'b0, 5'h02, 5'h08, 1'b0, 1'b0, '0);
    idle(12, 5'h0A, 5'h08);
    cyc(1'b0, 5'h0A, 5'h08, 1'b1, 1'b1, '0);
    chk(broken_o, 5'h04, "R5 grant move and drop restart window");

    // R8: host clear
    cyc(1'b0, 5'h04, 5'h02, 1'b1, 1'b1, 5'h04);
    cyc(1'b0, 5'h04, 5'h02, 1'b1, 1'b1, '0);
    chk(broken_o, '0, "R8 clear takes effect");
    chk(req_out, 5'h04, "R8 request unmasked");

    // R8: clear on the detection clock wins
    cyc(1'b0, 5'h01, 5'h01, 1'b1, 1'b0, '0);
    idle(15, 5'h01, 5'h01);
    cyc(1'b0, 5'h01, 5'h01, 1'b0, 1'b0, 5'h01);
    cyc(1'b0, 5'h01, 5'h01, 1'b1, 1'b0, '0);
    chk(broken_o, '0, "R8 clear beats detection");
    chk({4'b0, report_o}, '0, "R8 no report on cleared detection");

    // master 0 stalls for real, then reset clears it (R9)
    idle(17, 5'h01, 5'h01);
    cyc(1'b0, 5'h01, 5'h01, 1'b1, 1'b0, '0);
    chk(broken_o, 5'h01, "R3 on-chip master flagged");
    cyc(1'b1, 5'h01, 5'h01, 1'b0, 1'b0, '0);
    cyc(1'b0, 5'h01, 5'h01, 1'b1, 1'b0, '0);
    chk(broken_o, '0, "R9 reset clears flags");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule